// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a vertical sync signal from a composite sync stream, for example the sync recovered from the green channel, sampled on a slow reference clock (nominally 5 MHz). The incoming sync passes through a synchronizer and a polarity normalizer. A counter then measures how long the current sync level has lasted, in reference clock periods. Horizontal sync and equalization pulses are short. The broad, serrated pulses of the vertical interval are long. Only a level held for at least the programmed threshold changes the separated output.

While the separated output is low, the counter times active sync, and an active run that reaches the threshold drives the output high. While the output is high, the counter times inactive sync, and an inactive run that reaches the threshold drives it low again. This ends the vertical interval. Short serration gaps inside the vertical interval therefore leave the output high. The threshold must be set above the widest horizontal or equalization pulse. A zero threshold switches the separator off. Every change of the output comes with a one-cycle strobe.

Top module: `csync_vsep`

## Requirements
- R1: After reset, `vsep_out` and `vsep_stb` are low.
- R2: `csync_in` is synchronized through `SYNC_STAGES` flops (default 2). `csync_low` = 1 treats a low input as active sync, and `csync_low` = 0 treats a high input as active. Both polarities give identical output timing.
- R3: With `vsep_out` low and a nonzero threshold T, an active level held for at least T reference periods makes `vsep_out` rise. The rise occurs on rising edge T+2, counting as edge 1 the first edge that samples the new input level.
- R4: An active pulse held for fewer than T periods never changes `vsep_out`, however often it repeats.
- R5: With `vsep_out` high, an inactive interval held for at least T periods makes `vsep_out` fall, with the same edge timing as R3. Inactive gaps shorter than T leave the output high.
- R6: While `thresh` is 0, `vsep_out` stays low and `vsep_stb` never pulses.
- R7: `vsep_stb` is high for exactly one cycle, in the same cycle that `vsep_out` takes its new value, and is low at all other times. The only exception is a forced drop caused by a zero threshold.
- R8: If `thresh` is lowered to a value at or below a count already in progress, the output toggles on the next edge. The counter saturates and never wraps.
- R9: At the largest threshold (255), an active run of 254 periods does not toggle the output and a run of 255 periods does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 5 MHz) |
| rst_n | input | 1 | Synchronous reset, active low |
| csync_in | input | 1 | Composite sync, asynchronous to clk |
| csync_low | input | 1 | 1 = sync active low, 0 = active high |
| thresh | input | TH_W | Width threshold in reference periods; 0 disables |
| vsep_out | output | 1 | Separated vertical sync, active high |
| vsep_stb | output | 1 | One-cycle strobe on each change of vsep_out |

## Verification
Two functions can land on the same edge. The first is a threshold comparison that switches because `thresh` changed, which coincides with a count still in progress. To provoke it, the bench holds an active run past ten periods under a threshold of 20 and then lowers `thresh` to 4. It requires the toggle and the strobe on the very next edge. The second is the end of the vertical interval, where the counter's clear on a level change meets the output toggle. Back-to-back serrated and inactive segments whose lengths equal the threshold exactly test this case. The scoreboard checks the predicted edge number and the level of every strobe.

// File: rtl/csv_pkg.sv
// Shared constants for the composite sync vertical separator.
// Assumes: thresholds are unsigned counts of reference clock periods.
package csv_pkg;
    localparam int unsigned CSV_TH_W_DEF  = 8;
    localparam int unsigned CSV_STAGE_DEF = 2;

    // Which sync level the width counter is currently timing
    typedef enum logic {
        MEAS_ACTIVE   = 1'b0,
        MEAS_INACTIVE = 1'b1
    } csv_meas_e;
endpackage

// File: rtl/csv_sync.sv
// Brings the asynchronous composite sync into the clock domain through a
// flop chain and normalizes it so that 1 means sync active.
// Assumes: STAGES >= 2; polarity is static outside of reset.
module csv_sync #(
    parameter int unsigned STAGES = csv_pkg::CSV_STAGE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_low,
    output logic sync_act
);
    logic [STAGES-1:0] chain;

    // First stage captures the raw pin; reset loads the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= act_low;
        else        chain[0] <= raw_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage retimes the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= act_low;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign sync_act = chain[STAGES-1] ^ act_low;

    // R2
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !sync_act);
endmodule

// File: rtl/csv_width_cnt.sv
// Times the current sync run. It counts active sync while the output is
// low and inactive sync while it is high, then flags when the run
// reaches the threshold. It clears on a level change or on a flag, and
// saturates at its maximum value.
// Assumes: thresh of zero means separation is disabled.
module csv_width_cnt #(
    parameter int unsigned TH_W = csv_pkg::CSV_TH_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_act,
    input  logic            vs_level,
    input  logic [TH_W-1:0] thresh,
    output logic            reach
);
    import csv_pkg::*;

    localparam logic [TH_W-1:0] CNT_MAX = {TH_W{1'b1}};

    csv_meas_e       mode;
    logic            meas;
    logic [TH_W-1:0] cnt;
    logic [TH_W:0]   cnt_inc;

    // Pick which level is being timed from the current output state
    always_comb begin
        mode    = vs_level ? MEAS_INACTIVE : MEAS_ACTIVE;
        meas    = (mode == MEAS_INACTIVE) ? !sync_act : sync_act;
        cnt_inc = {1'b0, cnt} + 1'b1;
        reach   = meas && (thresh != '0) && (cnt_inc >= {1'b0, thresh});
    end

    // Run counter: clears off-level or on reach, saturates otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!meas || reach)    cnt <= '0;
        else if (cnt != CNT_MAX)    cnt <= cnt + 1'b1;
    end

    // R4
    cnt_clear_off_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas |=> (cnt == '0));
    // R8
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == CNT_MAX && $past(meas) && !$past(reach)) |-> (cnt == CNT_MAX));
endmodule

// File: rtl/csv_out_ctl.sv
// Holds the separated vertical sync level and the change strobe.
// Assumes: reach is only raised when the threshold is nonzero.
module csv_out_ctl #(
    parameter int unsigned TH_W = csv_pkg::CSV_TH_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reach,
    input  logic [TH_W-1:0] thresh,
    output logic            vs_level,
    output logic            vs_stb
);
    // Toggle on reach; a zero threshold forces the output low
    always_ff @(posedge clk) begin
        if (!rst_n)               vs_level <= 1'b0;
        else if (thresh == '0)    vs_level <= 1'b0;
        else if (reach)           vs_level <= !vs_level;
    end

    // Strobe mirrors a toggle for a single cycle
    always_ff @(posedge clk) begin
        if (!rst_n) vs_stb <= 1'b0;
        else        vs_stb <= reach && (thresh != '0);
    end

    // R6
    zero_thresh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) |=> (!vs_level && !vs_stb));
    // R7
    change_has_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_level != $past(vs_level) && $past(thresh) != '0) |-> vs_stb);
    // R7
    stb_has_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_stb |-> (vs_level != $past(vs_level)));
endmodule

// File: rtl/csync_vsep.sv
// Composite sync vertical separator top. A synchronizer feeds a run
// counter, and the counter drives the output toggle stage.
// Assumes: clk is the slow reference clock; csync_low is changed only
// while rst_n is low.
module csync_vsep #(
    parameter int unsigned TH_W        = csv_pkg::CSV_TH_W_DEF,
    parameter int unsigned SYNC_STAGES = csv_pkg::CSV_STAGE_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csync_in,
    input  logic            csync_low,
    input  logic [TH_W-1:0] thresh,
    output logic            vsep_out,
    output logic            vsep_stb
);
    logic sync_act;
    logic reach;

    csv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (csync_in),
        .act_low  (csync_low),
        .sync_act (sync_act)
    );

    csv_width_cnt #(.TH_W(TH_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_act (sync_act),
        .vs_level (vsep_out),
        .thresh   (thresh),
        .reach    (reach)
    );

    csv_out_ctl #(.TH_W(TH_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .reach    (reach),
        .thresh   (thresh),
        .vs_level (vsep_out),
        .vs_stb   (vsep_stb)
    );

    // R3
    rise_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsep_out) |-> $past(sync_act));
    // R5
    fall_needs_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsep_out) && $past(thresh) != '0) |-> !$past(sync_act));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!vsep_out && !vsep_stb));
endmodule

// File: tb/test_csync_vsep.sv
module test_csync_vsep;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csync_in = 1'b0;
    logic       csync_low = 1'b0;
    logic [7:0] thresh = 8'd4;
    logic       vsep_out;
    logic       vsep_stb;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { int at; bit lvl; } ev_t;
    ev_t q[$];
    bit  model_lvl = 0;
    bit  mon_lvl = 0;

    always #10 clk = ~clk;

    csync_vsep i_csync_vsep (
        .clk(clk), .rst_n(rst_n), .csync_in(csync_in), .csync_low(csync_low),
        .thresh(thresh), .vsep_out(vsep_out), .vsep_stb(vsep_stb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops an expected item on every strobe and compares it
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vsep_stb) begin
                if (q.size() == 0) begin
                    check(0, "R7 unexpected strobe", 1, 0);
                end else begin
                    ev_t e;
                    e = q.pop_front();
                    check(cyc == e.at, "R3/R5 toggle edge", cyc, e.at);
                    check(vsep_out == e.lvl, "R3/R5 level at strobe", vsep_out, e.lvl);
                    mon_lvl = e.lvl;
                end
            end else if (vsep_out != mon_lvl) begin
                check(0, "R7 level change without strobe", vsep_out, mon_lvl);
            end
        end
    end

    // Driver: hold a sync level for len periods and predict any toggle
    task automatic seg(input bit act, input int len);
        int  n;
        bit  meas;
        ev_t e;
        csync_in = act ^ csync_low;
        n = cyc;
        if (thresh != 0) begin
            meas = model_lvl ? !act : act;
            if (meas && len >= thresh) begin
                e.at = n + 2 + thresh;
                e.lvl = !model_lvl;
                q.push_back(e);
                model_lvl = !model_lvl;
            end
        end
        repeat (len) @(negedge clk);
    endtask

    task automatic do_reset(input bit pol);
        @(negedge clk);
        rst_n = 1'b0;
        csync_low = pol;
        csync_in = pol;
        repeat (4) @(negedge clk);
        check(vsep_out == 0 && vsep_stb == 0, "R1 reset outputs", {vsep_out, vsep_stb}, 0);
        rst_n = 1'b1;
        model_lvl = 0;
        mon_lvl = 0;
    endtask

    task automatic drain(input string req);
        repeat (8) @(negedge clk);
        check(q.size() == 0, req, q.size(), 0);
    endtask

    task automatic vertical_field();
        for (int i = 0; i < 5; i++) begin seg(1, 3); seg(0, 12); end
        for (int i = 0; i < 4; i++) begin seg(1, 9); seg(0, 2); end
        seg(1, 9);
        seg(0, 20);
        for (int i = 0; i < 3; i++) begin seg(1, 3); seg(0, 12); end
    endtask

    initial begin
        // R1 reset state, high-active polarity
        do_reset(0);
        seg(0, 10);
        // R4 horizontal and equalization pulses, one period short of T
        for (int i = 0; i < 10; i++) begin seg(1, 3); seg(0, 6); end
        drain("R4 short pulses no toggle");
        check(vsep_out == 0, "R4 output stays low", vsep_out, 0);
        // R3 R5 serrated vertical interval
        vertical_field();
        drain("R5 vertical interval events");
        check(vsep_out == 0, "R5 output low after interval", vsep_out, 0);
        // R3 R5 exact-threshold runs back to back
        seg(1, 4); seg(0, 4); seg(1, 3); seg(0, 5);
        drain("R3 exact threshold runs");

        // R2 inverted polarity, same stimulus and timing
        do_reset(1);
        seg(0, 10);
        vertical_field();
        drain("R2 low-active polarity events");

        // R6 zero threshold disables separation
        thresh = 8'd0;
        seg(1, 100); seg(0, 20); seg(1, 60);
        seg(0, 10);
        drain("R6 no events at zero threshold");
        check(vsep_out == 0, "R6 output held low", vsep_out, 0);

        // R8 threshold lowered below a running count
        begin
            ev_t e;
            int  n;
            thresh = 8'd20;
            csync_in = 1'b1 ^ csync_low;
            n = cyc;
            repeat (12) @(negedge clk);
            thresh = 8'd4;
            e.at = n + 13; e.lvl = 1'b1;
            q.push_back(e);
            model_lvl = 1;
            repeat (5) @(negedge clk);
            seg(0, 10);
        end
        drain("R8 toggle on next edge after lowering");
        check(vsep_out == 0, "R8 output back low", vsep_out, 0);

        // R9 largest threshold boundary
        thresh = 8'd255;
        seg(1, 254); seg(0, 300);
        drain("R9 254 periods no toggle");
        check(vsep_out == 0, "R9 still low after 254", vsep_out, 0);
        seg(1, 255); seg(0, 255); seg(1, 3); seg(0, 10);
        drain("R9 255 periods toggle and return");
        check(vsep_out == 0, "R9 low at end", vsep_out, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule